// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block turns a programmed period and a 10-bit duty value into one pulse-width modulated output. Its time base is an 8-bit timer joined below by a 2-bit sub-count, which gives 10 bits. The sub-count advances once every prescale clocks, and the timer advances each time the sub-count wraps. A period runs until the timer reaches the period setting at the end of its last sub-count step. At that point the timer restarts and a new period begins.

The duty value arrives as an 8-bit upper part and a 2-bit lower part, and either part may change at any moment. The generator never compares against those inputs directly. At each period start it copies them into a read-only shadow register, and the output is driven from the shadow. A duty change therefore never cuts a period short or stretches it. A 2-bit mode field turns the generator on. Any value other than the run code holds the time base idle and forces the output low.

Top module: `pwm10_dbuf`

## Requirements
- R1: While reset is asserted, and after it until the generator is enabled, `pwm_o` is 0 and `shadow_o` is 0.
- R2: While running, one period lasts exactly 4 × P × (`period_i` + 1) clocks, and successive periods repeat with no gap.
- R3: `presc_i` selects the prescale factor P. The code 2'b00 gives P = 1, 2'b01 gives P = 4, and 2'b10 or 2'b11 gives P = 16.
- R4: The duty value D is {`duty_hi_i`, `duty_lo_i`}, with `duty_lo_i` as the two least significant bits. When 0 < D < 4 × (`period_i` + 1), `pwm_o` is high for the first D × P clocks of each period and low for the rest.
- R5: A duty change made partway through a period leaves that period's high time and `shadow_o` unchanged. The new value appears on `shadow_o` and governs the high time starting with the next period.
- R6: When the latched duty is 0, `pwm_o` stays low for the whole period.
- R7: When the latched duty is at least 4 × (`period_i` + 1), `pwm_o` stays high for the whole period.
- R8: When `mode_i` is not 2'b11, `pwm_o` is 0 from the next clock edge onward, and the time base returns to zero. `shadow_o` holds its value while the generator is stopped. The first clock edge with `mode_i` = 2'b11 starts a new period and latches the current duty inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Run control; 2'b11 runs the generator, any other value stops it |
| presc_i | input | 2 | Prescale select (÷1, ÷4, ÷16) |
| period_i | input | 8 | Period setting; the timer restarts after reaching it |
| duty_hi_i | input | 8 | Upper eight bits of the duty value |
| duty_lo_i | input | 2 | Lower two bits of the duty value |
| pwm_o | output | 1 | PWM output |
| shadow_o | output | 10 | Read-only latched duty value in use |

## Verification
The hardest case to reach from the ports is a duty change that arrives partway through a running period. It must leave both the output and the shadow untouched until the period boundary. The bench starts a period with a known duty and, at a fixed sample in the middle of that period, drives a new duty. It then checks that the high time of the current period and `shadow_o` still reflect the old value, and that the following period switches to the new one. A second directed case stops the generator during a high phase and changes the duty while it is stopped. It then checks that the output drops at once and that the shadow keeps the old value until the generator is started again.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    localparam logic [1:0] MODE_RUN = 2'b11;

    // prescale select -> log2 of the divide factor
    function automatic logic [2:0] presc_shift(input logic [1:0] sel);
        logic [2:0] sh;
        case (sel)
            2'b00:   sh = 3'd0;
            2'b01:   sh = 3'd2;
            default: sh = 3'd4;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int SUB_W = 2,
    parameter int PSH_W = 4,
    localparam int PRE_W = SUB_W + PSH_W,
    localparam int TB_W  = TMR_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [1:0]       presc_i,
    input  logic [TMR_W-1:0] period_i,
    output logic [TB_W-1:0]  tb_next_o,
    output logic             load_o
);

    typedef struct packed {
        logic             run;
        logic [TMR_W-1:0] tmr;
        logic [PRE_W-1:0] pre;
    } tb_state_t;

    tb_state_t        s_d, s_q;
    logic [2:0]       shift;
    logic [PRE_W-1:0] lim;
    logic             wrap;
    logic             boundary;
    logic             start;
    logic [SUB_W-1:0] sub_next;

    always_comb begin
        s_d      = s_q;
        shift    = presc_shift(presc_i);
        lim      = {PRE_W{1'b1}} >> (PSH_W - int'(shift));
        wrap     = (s_q.pre >= lim);
        boundary = s_q.run && wrap && (s_q.tmr == period_i);
        start    = !s_q.run;
        if (!run_i) begin
            s_d = '0;
        end else if (start) begin
            s_d.run = 1'b1;
            s_d.tmr = '0;
            s_d.pre = '0;
        end else if (wrap) begin
            s_d.pre = '0;
            s_d.tmr = boundary ? '0 : s_q.tmr + 1'b1;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
        sub_next  = SUB_W'(s_d.pre >> shift);
        tb_next_o = {s_d.tmr, sub_next};
        load_o    = run_i && (start || boundary);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: a completed period restarts the timer from zero
    p_period_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && s_q.run && wrap && (s_q.tmr == period_i)) |=> (s_q.tmr == '0 && s_q.pre == '0));

    // R8: stopping returns the time base to zero
    p_halt_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (s_q.tmr == '0 && s_q.pre == '0 && !s_q.run));

endmodule

// File: rtl/pwm10_dutylatch.sv
module pwm10_dutylatch #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] duty_i,
    output logic [DW-1:0] shadow_next_o,
    output logic [DW-1:0] shadow_o
);

    typedef struct packed {
        logic [DW-1:0] shadow;
    } dl_state_t;

    dl_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) s_d.shadow = duty_i;
        shadow_next_o = s_d.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shadow_o = s_q.shadow;

    // R5: shadow only changes on a period-start load
    p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(s_q.shadow));

    // R5: a load captures the duty inputs of that cycle
    p_shadow_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (s_q.shadow == $past(duty_i)));

endmodule

// File: rtl/pwm10_outstage.sv
module pwm10_outstage #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [DW-1:0] tb_next_i,
    input  logic [DW-1:0] shadow_next_i,
    output logic          pwm_o
);

    typedef struct packed {
        logic out;
    } os_state_t;

    os_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.out = run_i && (tb_next_i < shadow_next_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_o = s_q.out;

    // R8: a stop request forces the output low on the next edge
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pwm_o);

endmodule

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int SUB_W = 2,
    parameter int PSH_W = 4,
    localparam int DW   = TMR_W + SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       presc_i,
    input  logic [TMR_W-1:0] period_i,
    input  logic [TMR_W-1:0] duty_hi_i,
    input  logic [SUB_W-1:0] duty_lo_i,
    output logic             pwm_o,
    output logic [DW-1:0]    shadow_o
);

    logic          run;
    logic          load;
    logic [DW-1:0] tb_next;
    logic [DW-1:0] shadow_next;
    logic [DW-1:0] duty_in;

    assign run     = (mode_i == MODE_RUN);
    assign duty_in = {duty_hi_i, duty_lo_i};

    pwm10_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W), .PSH_W(PSH_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .presc_i   (presc_i),
        .period_i  (period_i),
        .tb_next_o (tb_next),
        .load_o    (load)
    );

    pwm10_dutylatch #(.DW(DW)) u_dl (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load),
        .duty_i        (duty_in),
        .shadow_next_o (shadow_next),
        .shadow_o      (shadow_o)
    );

    pwm10_outstage #(.DW(DW)) u_os (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run),
        .tb_next_i     (tb_next),
        .shadow_next_i (shadow_next),
        .pwm_o         (pwm_o)
    );

    // R6: a zero latched duty never drives the output high
    p_zero_duty_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_o == '0) |-> !pwm_o);

    // R1: coming out of reset the output is low
    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pwm_o);

endmodule

// File: tb/sim_pwm10_dbuf.sv
module sim_pwm10_dbuf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [1:0] presc_i = 2'b00;
    logic [7:0] period_i = 8'd0;
    logic [7:0] duty_hi_i = 8'd0;
    logic [1:0] duty_lo_i = 2'd0;
    logic       pwm_o;
    logic [9:0] shadow_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    pwm10_dbuf u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .presc_i   (presc_i),
        .period_i  (period_i),
        .duty_hi_i (duty_hi_i),
        .duty_lo_i (duty_lo_i),
        .pwm_o     (pwm_o),
        .shadow_o  (shadow_o)
    );

    // {period, presc, duty}
    localparam logic [19:0] VEC [0:7] = '{
        {8'd4, 2'd0, 10'd7},     // R4 basic, P=1
        {8'd9, 2'd1, 10'd13},    // R3 P=4
        {8'd2, 2'd2, 10'd5},     // R3 P=16
        {8'd0, 2'd0, 10'd2},     // R2 shortest period
        {8'd7, 2'd3, 10'd13},    // R3 alt code, R4 low bits used
        {8'd5, 2'd0, 10'd0},     // R6 zero duty
        {8'd3, 2'd1, 10'd16},    // R7 duty equal to period length
        {8'd3, 2'd0, 10'd1000}   // R7 duty far above period length
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pfac(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : 16;
    endfunction

    // samples n negedges, expecting high for the first h of them
    task automatic run_period(input int n, input int h, input string req);
        int bad = 0;
        int hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_o) hi++;
            if (pwm_o !== (k < h)) bad++;
        end
        check(bad == 0 && hi == h, req, hi, h);
    endtask

    task automatic stop_and_config(input logic [7:0] pr, input logic [1:0] ps, input logic [9:0] d);
        @(negedge clk);
        mode_i    = 2'b00;
        period_i  = pr;
        presc_i   = ps;
        duty_hi_i = d[9:2];
        duty_lo_i = d[1:0];
        @(negedge clk);
        mode_i = 2'b11;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with run code applied
        mode_i = 2'b11;
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b0, "R1", int'(pwm_o), 0);
        check(shadow_o == 10'd0, "R1", int'(shadow_o), 0);
        mode_i = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b0 && shadow_o == 10'd0, "R1", int'(pwm_o), 0);

        // table walk: R2, R3, R4, R6, R7
        for (int i = 0; i < 8; i++) begin
            logic [7:0] pr;
            logic [1:0] ps;
            logic [9:0] d;
            int p, n, full, h;
            {pr, ps, d} = VEC[i];
            p    = pfac(ps);
            full = 4 * (int'(pr) + 1);
            n    = full * p;
            h    = ((int'(d) < full) ? int'(d) : full) * p;
            stop_and_config(pr, ps, d);
            run_period(n, h, "R2/R3/R4/R6/R7 first period");
            check(shadow_o == d, "R5 shadow after start", int'(shadow_o), int'(d));
            run_period(n, h, "R2 second period");
        end

        // R5: mid-period duty change waits for the next period
        stop_and_config(8'd9, 2'b00, 10'd10);
        begin
            int hi = 0;
            int bad = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (pwm_o) hi++;
                if (pwm_o !== (k < 10)) bad++;
                if (k == 5) begin
                    duty_hi_i = 8'd7;   // 30 = {7, 2}
                    duty_lo_i = 2'd2;
                end
                if (k == 20)
                    check(shadow_o == 10'd10, "R5 shadow mid-period", int'(shadow_o), 10);
            end
            check(bad == 0 && hi == 10, "R5 current period unchanged", hi, 10);
        end
        run_period(40, 30, "R5 next period uses new duty");
        check(shadow_o == 10'd30, "R5 shadow updated", int'(shadow_o), 30);

        // R8: stop during high phase, shadow holds, restart latches
        stop_and_config(8'd4, 2'b00, 10'd100);
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b1, "R7 full duty high", int'(pwm_o), 1);
        mode_i = 2'b01;
        duty_hi_i = 8'd1;
        duty_lo_i = 2'd2;   // 6
        @(negedge clk);
        check(pwm_o == 1'b0, "R8 stop forces low", int'(pwm_o), 0);
        mode_i = 2'b10;
        repeat (4) @(negedge clk);
        check(pwm_o == 1'b0, "R8 stays low", int'(pwm_o), 0);
        check(shadow_o == 10'd100, "R8 shadow held", int'(shadow_o), 100);
        mode_i = 2'b11;
        run_period(20, 6, "R8 restart latches duty");
        check(shadow_o == 10'd6, "R8 shadow after restart", int'(shadow_o), 6);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule